// File: doc/BRIEF.md
# Timekeeper I2C Register Slave

This block is the two-wire serial front end of a timekeeping device. An external master reaches a 64-byte space of clock registers and battery-backed RAM through it. SCL and SDA are first brought into the system clock domain. The block then finds START, repeated START and STOP on the bus. It answers only to the device address 1101000 and keeps a word-address pointer inside. With these it serves multi-byte writes, random reads, sequential reads and current-address reads. Written bytes leave on a one-cycle register-file write port. Read bytes come either from the register file or from an internal copy of the clock registers.

The running clock counters feed a live bus of eight bytes. A user-side copy of those bytes follows the live bus on every cycle. While the master reads a clock address, the copy stops following. A time value read as several bytes therefore comes from a single instant. The copy follows the live bus again after STOP, or once the pointer moves past the last clock address into RAM.

Top module: `tk_i2c_regslave`

## Requirements
- R1: The device address 7'b1101000 (byte 8'hD0 to write, 8'hD1 to read) is acknowledged. A byte with any other address gets no acknowledge, and SDA stays released and no write is issued until the next START or STOP.
- R2: After a write-direction address has been acknowledged, the next byte is acknowledged and its low 6 bits are loaded into the pointer.
- R3: Each later byte of a write is acknowledged. It appears on the write port as a single-cycle wr_en_o with wr_addr_o equal to the pointer. The pointer increments when that acknowledge clock ends.
- R4: The pointer is 6 bits wide and wraps from 3Fh to 00h.
- R5: After a repeated START and a read-direction address, the byte at the pointer is sent MSB first.
- R6: During a read, the pointer increments only when the master acknowledges. A byte the master does not acknowledge leaves the pointer unchanged.
- R7: A master NACK ends the transfer. SDA stays released for any further clocks until START or STOP.
- R8: A read that does not first set the pointer starts at the address the pointer already holds.
- R9: Addresses 00h to 07h are read from the user-side clock copy. Addresses 08h to 3Fh are read from rd_data_i at rd_addr_o.
- R10: snap_o takes live_clk_i every cycle, except while a read is in progress at a clock address. During that time it holds its value.
- R11: The hold ends on STOP, or when the pointer increments from a clock address into RAM.
- R12: After reset, SDA is released, no write is issued and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain) |
| live_clk_i | input | 64 | Running clock registers, byte n at bits 8n+7:8n |
| snap_o | output | 64 | User-side copy of the clock registers |
| rd_addr_o | output | 6 | Register-file read address (the pointer) |
| rd_data_i | input | 8 | Register-file read data, combinational |
| wr_en_o | output | 1 | Single-cycle register-file write strobe |
| wr_addr_o | output | 6 | Register-file write address |
| wr_data_o | output | 8 | Register-file write data |

## Verification
A bad pointer shows up in the very next data byte. A read returns the wrong address, or a current-address read after a NACK starts one byte off. A write lands at a wrong wr_addr_o within one byte time. If the hold flag is stuck or cleared early, snap_o moves while a clock address is being read, and the second byte of a time read comes from the new live value. The bench changes the live bus between bytes so that this case appears. A state machine out of step pulls SDA low when it should not. That shows up as a missing or extra acknowledge within one bit time.

// File: rtl/tk_i2c_pkg.sv
package tk_i2c_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_PTR,
      ST_PTR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_HOLD
   } slv_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/tk_i2c_sync_edge.sv
module tk_i2c_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tk_i2c_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_d, sda_d;
   logic              scl_s, sda_s;

   assign scl_s = scl_ff[STAGES-1];
   assign sda_s = sda_ff[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_d;
   assign scl_fall_o = ~scl_s & scl_d;
   assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tk_i2c_snapshot.sv
module tk_i2c_snapshot #(
   parameter int unsigned CLK_REGS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold_i,
   input  logic [CLK_REGS*8-1:0]   live_i,
   output logic [CLK_REGS*8-1:0]   snap_o
);

   genvar gi;
   generate
      for (gi = 0; gi < CLK_REGS; gi++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               snap_o[gi*8 +: 8] <= '0;
            else if (!hold_i)
               snap_o[gi*8 +: 8] <= live_i[gi*8 +: 8];
         end
      end
   endgenerate

endmodule

// File: rtl/tk_i2c_engine.sv
module tk_i2c_engine
   import tk_i2c_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned CLK_REGS = 8,
   parameter logic [6:0]  DEV_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              sda_s_i,
   input  logic [7:0]        tx_byte_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              sda_oe_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              frz_o,
   output logic              hold_o
);

   slv_state_e        st_q;
   logic [3:0]        bcnt_q;
   logic [7:0]        sh_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_inc;
   logic              oe_q, wr_q, frz_q, rd_q, mack_q;
   logic [ADDR_W-1:0] wa_q;
   logic [7:0]        wd_q;
   logic              in_clk, inc_in_clk;

   assign ptr_inc    = ptr_q + 1'b1;
   assign in_clk     = (int'(ptr_q) < int'(CLK_REGS));
   assign inc_in_clk = (int'(ptr_inc) < int'(CLK_REGS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bcnt_q <= '0;
         sh_q   <= '0;
         ptr_q  <= '0;
         oe_q   <= 1'b0;
         wr_q   <= 1'b0;
         frz_q  <= 1'b0;
         rd_q   <= 1'b0;
         mack_q <= 1'b0;
         wa_q   <= '0;
         wd_q   <= '0;
      end else begin
         wr_q <= 1'b0;
         if (stop_i) begin
            st_q  <= ST_IDLE;
            oe_q  <= 1'b0;
            frz_q <= 1'b0;
         end else if (start_i) begin
            st_q   <= ST_DEV;
            bcnt_q <= '0;
            oe_q   <= 1'b0;
         end else begin
            unique case (st_q)
               ST_DEV, ST_PTR, ST_WR: begin
                  if (scl_rise_i) begin
                     sh_q   <= {sh_q[6:0], sda_s_i};
                     bcnt_q <= bcnt_q + 4'd1;
                  end else if (scl_fall_i && bcnt_q == 4'd8) begin
                     bcnt_q <= '0;
                     if (st_q == ST_DEV) begin
                        if (sh_q[7:1] == DEV_ADDR) begin
                           oe_q <= 1'b1;
                           rd_q <= sh_q[0];
                           st_q <= ST_DEV_ACK;
                        end else begin
                           st_q <= ST_HOLD;
                        end
                     end else if (st_q == ST_PTR) begin
                        ptr_q <= sh_q[ADDR_W-1:0];
                        oe_q  <= 1'b1;
                        st_q  <= ST_PTR_ACK;
                     end else begin
                        wr_q <= 1'b1;
                        wa_q <= ptr_q;
                        wd_q <= sh_q;
                        oe_q <= 1'b1;
                        st_q <= ST_WR_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall_i) begin
                     bcnt_q <= '0;
                     if (rd_q) begin
                        sh_q <= tx_byte_i;
                        oe_q <= ~tx_byte_i[7];
                        st_q <= ST_TX;
                        if (in_clk) frz_q <= 1'b1;
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_PTR;
                     end
                  end
               end
               ST_PTR_ACK: begin
                  if (scl_fall_i) begin
                     oe_q <= 1'b0;
                     st_q <= ST_WR;
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall_i) begin
                     oe_q  <= 1'b0;
                     ptr_q <= ptr_inc;
                     st_q  <= ST_WR;
                  end
               end
               ST_TX: begin
                  if (scl_rise_i) begin
                     bcnt_q <= bcnt_q + 4'd1;
                  end else if (scl_fall_i) begin
                     if (bcnt_q == 4'd8) begin
                        oe_q <= 1'b0;
                        st_q <= ST_TX_ACK;
                     end else begin
                        sh_q <= {sh_q[6:0], 1'b0};
                        oe_q <= ~sh_q[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise_i) begin
                     mack_q <= ~sda_s_i;
                     if (!sda_s_i) begin
                        ptr_q <= ptr_inc;
                        if (!inc_in_clk) frz_q <= 1'b0;
                     end
                  end else if (scl_fall_i) begin
                     if (mack_q) begin
                        bcnt_q <= '0;
                        sh_q   <= tx_byte_i;
                        oe_q   <= ~tx_byte_i[7];
                        st_q   <= ST_TX;
                        if (in_clk) frz_q <= 1'b1;
                     end else begin
                        st_q <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ptr_o     = ptr_q;
   assign sda_oe_o  = oe_q;
   assign wr_en_o   = wr_q;
   assign wr_addr_o = wa_q;
   assign wr_data_o = wd_q;
   assign frz_o     = frz_q;
   assign hold_o    = (st_q == ST_HOLD);

endmodule

// File: rtl/tk_i2c_regslave.sv
module tk_i2c_regslave #(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned CLK_REGS    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'h68
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [CLK_REGS*8-1:0] live_clk_i,
   output logic [CLK_REGS*8-1:0] snap_o,
   output logic [ADDR_W-1:0]     rd_addr_o,
   input  logic [7:0]            rd_data_i,
   output logic                  wr_en_o,
   output logic [ADDR_W-1:0]     wr_addr_o,
   output logic [7:0]            wr_data_o
);

   localparam int unsigned SPACE = 1 << ADDR_W;

   generate
      if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_addr
         $error("tk_i2c_regslave: ADDR_W must be 3..8");
      end
      if (CLK_REGS < 1 || CLK_REGS >= SPACE) begin : g_bad_regs
         $error("tk_i2c_regslave: CLK_REGS must leave room for RAM");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [ADDR_W-1:0] ptr;
   logic              frz, hold_w;
   logic [7:0]        snap_sel, tx_byte;

   tk_i2c_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det)
   );

   tk_i2c_snapshot #(.CLK_REGS(CLK_REGS)) u_snap (
      .clk(clk), .rst_n(rst_n), .hold_i(frz),
      .live_i(live_clk_i), .snap_o(snap_o)
   );

   always_comb begin
      snap_sel = '0;
      for (int i = 0; i < int'(CLK_REGS); i++)
         if (int'(ptr) == i) snap_sel = snap_o[i*8 +: 8];
   end

   assign tx_byte   = (int'(ptr) < int'(CLK_REGS)) ? snap_sel : rd_data_i;
   assign rd_addr_o = ptr;

   tk_i2c_engine #(
      .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .DEV_ADDR(DEV_ADDR)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
      .start_i(start_det), .stop_i(stop_det), .sda_s_i(sda_s),
      .tx_byte_i(tx_byte), .ptr_o(ptr), .sda_oe_o(sda_oe_o),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .frz_o(frz), .hold_o(hold_w)
   );

endmodule

// File: rtl/tk_i2c_regslave_chk.sv
module tk_i2c_regslave_chk #(
   parameter int unsigned W = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic         sda_oe,
   input logic         frz,
   input logic         stop_det,
   input logic         hold,
   input logic [W-1:0] snap,
   input logic [W-1:0] live
);

   // R3: write strobe lasts exactly one cycle
   a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R1, R7: after a foreign address or master NACK, SDA stays released
   a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> !sda_oe);

   // R10: copy does not move while held
   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      frz |=> $stable(snap));

   // R10: copy follows live bus otherwise
   a_r10_track: assert property (@(posedge clk) disable iff (!rst_n)
      !frz |=> snap == $past(live));

   // R11: STOP releases the hold
   a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !frz);

endmodule

bind tk_i2c_regslave tk_i2c_regslave_chk #(.W(CLK_REGS*8)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en_o), .sda_oe(sda_oe_o),
   .frz(frz), .stop_det(stop_det), .hold(hold_w),
   .snap(snap_o), .live(live_clk_i)
);

// File: tb/sim_tk_i2c_regslave.sv
module sim_tk_i2c_regslave;

   localparam int CLK_PERIOD = 10;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic sda_bus;
   logic [63:0] live = '0;
   logic [63:0] snap;
   logic [5:0]  rd_addr, wr_addr;
   logic [7:0]  rd_data, wr_data;
   logic        wr_en;
   logic [7:0]  mem [64];
   int          wr_cnt = 0;
   int          oe_cnt = 0;
   int          n_chk = 0;
   int          n_err = 0;

   logic [7:0]  exp_q [$];
   string       tag_q [$];
   logic [7:0]  got_val;
   event        got_ev;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;
   assign rd_data = mem[rd_addr];

   tk_i2c_regslave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe_o(sda_oe), .live_clk_i(live), .snap_o(snap),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
   );

   function automatic logic [7:0] ram_init(int a);
      return 8'(a) ^ 8'h5A;
   endfunction

   function automatic logic [63:0] pat(logic [7:0] base);
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[i*8 +: 8] = base + 8'(i);
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= ram_init(i);
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
         wr_cnt <= wr_cnt + 1;
      end
      if (sda_oe) oe_cnt <= oe_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(got_ev) begin
      if (exp_q.size() == 0) begin
         check(1'b0, "scoreboard empty", {56'd0, got_val}, 64'd0);
      end else begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(got_val === e, t, {56'd0, got_val}, {56'd0, e});
      end
   end

   function automatic void expect_byte(string t, logic [7:0] v);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endfunction

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic i2c_rstart();
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
   endtask

   task automatic wbit(input logic b);
      sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic wbyte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         rbit(b);
         v[i] = b;
      end
      wbit(~mack);
      got_val = v;
      -> got_ev;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] v;
      int wc;
      int oc;
      live = pat(8'hA0);
      repeat (5) @(negedge clk);
      // R12: reset state
      check(sda_oe == 1'b0, "R12 sda released in reset", sda_oe, 0);
      check(wr_en == 1'b0, "R12 no write in reset", wr_en, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(rd_addr == 6'h00, "R12 pointer zero", rd_addr, 0);

      // R1 R2 R3: multi-byte write to 10h
      wc = wr_cnt;
      i2c_start();
      wbyte(8'hD0, ack); check(ack, "R1 address ack", ack, 1);
      wbyte(8'h10, ack); check(ack, "R2 word address ack", ack, 1);
      wbyte(8'h31, ack); check(ack, "R3 data ack", ack, 1);
      wbyte(8'h32, ack);
      wbyte(8'h33, ack); check(ack, "R3 last data ack", ack, 1);
      i2c_stop();
      check(wr_cnt - wc == 3, "R3 write count", wr_cnt - wc, 3);
      check(mem[6'h10] == 8'h31 && mem[6'h11] == 8'h32 && mem[6'h12] == 8'h33,
            "R3 written bytes", {mem[6'h10], mem[6'h11], mem[6'h12]}, 24'h313233);

      // R5 R6 random sequential read, last byte NACKed
      i2c_start();
      wbyte(8'hD0, ack); wbyte(8'h10, ack);
      i2c_rstart();
      wbyte(8'hD1, ack); check(ack, "R5 read address ack", ack, 1);
      expect_byte("R5 read 10h", 8'h31);
      expect_byte("R6 read 11h after ack", 8'h32);
      expect_byte("R6 read 12h after ack", 8'h33);
      rbyte(1'b1, v); rbyte(1'b1, v); rbyte(1'b0, v);
      i2c_stop();

      // R8 R6: current-address read, pointer stayed at 12h after NACK
      i2c_start();
      wbyte(8'hD1, ack);
      expect_byte("R8 R6 current read at 12h", 8'h33);
      rbyte(1'b0, v);
      i2c_stop();

      // R1: foreign address ignored
      wc = wr_cnt;
      i2c_start();
      wbyte(8'hA0, ack); check(!ack, "R1 foreign address nack", ack, 0);
      wbyte(8'h20, ack); check(!ack, "R1 no ack after foreign", ack, 0);
      wbyte(8'h99, ack);
      i2c_stop();
      check(wr_cnt == wc, "R1 no write after foreign", wr_cnt - wc, 0);

      // R7: after NACK no further driving
      i2c_start();
      wbyte(8'hD1, ack);
      expect_byte("R7 byte before nack", 8'h33);
      rbyte(1'b0, v);
      oc = oe_cnt;
      expect_byte("R7 released bus reads ones", 8'hFF);
      rbyte(1'b0, v);
      check(oe_cnt == oc, "R7 sda never driven after nack", oe_cnt - oc, 0);
      i2c_stop();

      // R4: wrap 3Fh -> 00h
      i2c_start();
      wbyte(8'hD0, ack); wbyte(8'h3F, ack);
      wbyte(8'h77, ack); wbyte(8'h88, ack);
      i2c_stop();
      check(mem[6'h3F] == 8'h77, "R4 write at 3Fh", mem[6'h3F], 8'h77);
      check(mem[6'h00] == 8'h88, "R4 wrapped write at 00h", mem[6'h00], 8'h88);
      // R9: pointer now 01h, a clock address served from the copy
      i2c_start();
      wbyte(8'hD1, ack);
      expect_byte("R9 R4 clock copy at 01h", 8'hA1);
      rbyte(1'b0, v);
      i2c_stop();

      // R10 R11 R9: frozen time read crossing into RAM
      i2c_start();
      wbyte(8'hD0, ack); wbyte(8'h06, ack);
      i2c_rstart();
      wbyte(8'hD1, ack);
      expect_byte("R10 clock byte 06h", 8'hA6);
      rbyte(1'b1, v);
      live = pat(8'hB0);
      repeat (4) @(negedge clk);
      check(snap == pat(8'hA0), "R10 copy held during time read", snap, pat(8'hA0));
      expect_byte("R10 clock byte 07h from held copy", 8'hA7);
      rbyte(1'b1, v);
      expect_byte("R9 RAM byte 08h", ram_init(8));
      rbyte(1'b1, v);
      check(snap == pat(8'hB0), "R11 copy resumes in RAM", snap, pat(8'hB0));
      expect_byte("R9 RAM byte 09h", ram_init(9));
      rbyte(1'b0, v);
      i2c_stop();

      // R11: STOP releases the hold
      i2c_start();
      wbyte(8'hD0, ack); wbyte(8'h02, ack);
      i2c_rstart();
      wbyte(8'hD1, ack);
      expect_byte("R10 clock byte 02h", 8'hB2);
      rbyte(1'b0, v);
      live = pat(8'hC0);
      repeat (4) @(negedge clk);
      check(snap == pat(8'hB0), "R10 held until STOP", snap, pat(8'hB0));
      i2c_stop();
      repeat (4) @(negedge clk);
      check(snap == pat(8'hC0), "R11 released by STOP", snap, pat(8'hC0));

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule